// File: doc/BRIEF.md
# Buffered UART Packet Transmitter

This block keeps a small byte buffer that is filled one 32-bit word at a time. It also has a two-entry register file with a packet length and a start register. Software first loads the bytes of a packet into the buffer. It then writes the length, and after that writes the start code 0x000000BA to the start register. The block then reads the buffer from byte 0 upward and sends each byte as a UART frame on a single idle-high line. A busy flag stays high from the start of the packet until the last stop bit has ended.

The buffer write port is a valid/ready stream that never applies back-pressure: `buf_wready` is held high, so every word offered with `buf_wvalid` is stored in that cycle. The register port follows AXI4-Lite write rules with an address channel, a data channel and a response channel. A register write is taken only in a cycle where both the address and the data are valid and no earlier response is still waiting. The response is then held until the master accepts it, and this back-pressure on `reg_bready` stalls any further register writes. The bit time is `CLK_HZ/BAUD` clock cycles, rounded to the nearest integer. With the defaults of 100 MHz and 115200 baud this is 868 cycles.

Top module: `uart_pkt_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the next cycle shows `tx` = 1, `busy` = 0 and `reg_bvalid` = 0, and the length register reads as zero.
- R2: `reg_awready` and `reg_wready` are high only when `reg_awvalid` and `reg_wvalid` are both high and `reg_bvalid` is low. An accepted write raises `reg_bvalid` in the next cycle, and `reg_bvalid` stays high until a cycle with `reg_bready` high.
- R3: A write to byte address 0x0 sets the packet length in bytes. The next started packet sends exactly that many frames.
- R4: A length written above the buffer size (2**ADDR_W bytes) is clamped to the buffer size.
- R5: A start with a length of zero sends no frame, and `busy` stays low.
- R6: Only a write of exactly 0x000000BA to byte address 0x4 starts a packet. Any other value at 0x4, and any write to another or unaligned address, has no effect.
- R7: A start write accepted while `busy` is high is ignored, and the packet in flight is neither extended nor restarted.
- R8: Bytes go out from buffer byte 0 in increasing address order. The word stored at word index k holds bytes 4k..4k+3, with the least significant byte at 4k. For example, 0xBA0321F1 is sent as F1, 21, 03, BA.
- R9: Each frame is a 0 start bit, then 8 data bits LSB first, then two stop bits at 1. There is no parity bit, and each bit lasts DIV = round(CLK_HZ/BAUD) cycles.
- R10: `busy` rises after an accepted start and stays high through the second stop bit of the last byte. Whenever `busy` is low, `tx` is high.
- R11: `buf_wready` is always high. A cycle with `buf_wvalid` high writes `buf_wdata` to word index `buf_widx`, and that word is used by later packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_wvalid | input | 1 | Buffer word write valid |
| buf_wready | output | 1 | Buffer write ready, always high |
| buf_widx | input | ADDR_W-2 | Buffer word index (byte address / 4) |
| buf_wdata | input | DATA_W | Buffer word, low byte at the lowest address |
| reg_awvalid | input | 1 | Register write address valid |
| reg_awready | output | 1 | Register write address ready |
| reg_awaddr | input | REG_AW | Register byte address |
| reg_wvalid | input | 1 | Register write data valid |
| reg_wready | output | 1 | Register write data ready |
| reg_wdata | input | DATA_W | Register write data |
| reg_bvalid | output | 1 | Write response valid |
| reg_bready | input | 1 | Write response ready |
| tx | output | 1 | Serial output, idle high |
| busy | output | 1 | Packet transmission in progress |

## Verification
The first packet has two hand-picked words with distinct byte values and a length of 8. Any byte-lane or word-order mistake therefore shows up as a wrong byte at a known position. A length of 5 stops partway through a word, which separates correct length counting from whole-word counting. A 256-byte length on a 64-byte buffer separates clamping from truncation or wrap-around. Zero length, wrong start codes, a start to a wrong or unaligned address, and a start during a packet are each followed by an idle window. These cases tell ignored stimulus apart from extra or restarted frames.

// File: rtl/uart_pkt_pkg.sv
package uart_pkt_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_FETCH,
    SQ_OFFER,
    SQ_DRAIN
  } seq_state_t;

  localparam int unsigned LEN_REG_ADDR  = 0;
  localparam int unsigned TRIG_REG_ADDR = 4;
  localparam logic [31:0] TRIG_CODE     = 32'h0000_00BA;

  function automatic int unsigned bit_cycles(input int unsigned clk_hz, input int unsigned baud);
    return (clk_hz + baud / 2) / baud;
  endfunction

endpackage

// File: rtl/pkt_regs.sv
module pkt_regs #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 4,
  parameter int unsigned BUF_BYTES = 1024,
  parameter int unsigned LEN_W     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [REG_AW-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  output logic              bvalid,
  input  logic              bready,
  output logic [LEN_W-1:0]  len_o,
  output logic              start_o
);
  import uart_pkt_pkg::*;

  localparam logic [DATA_W-1:0] MAX_LEN = DATA_W'(BUF_BYTES);

  logic take;
  assign take    = awvalid && wvalid && !bvalid;
  assign awready = take;
  assign wready  = take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bvalid  <= 1'b0;
      len_o   <= '0;
      start_o <= 1'b0;
    end else begin
      start_o <= 1'b0;
      if (take) begin
        bvalid <= 1'b1;
        if (awaddr == REG_AW'(LEN_REG_ADDR)) begin
          len_o <= (wdata > MAX_LEN) ? LEN_W'(BUF_BYTES) : LEN_W'(wdata);
        end else if (awaddr == REG_AW'(TRIG_REG_ADDR) && wdata == DATA_W'(TRIG_CODE)) begin
          start_o <= 1'b1;
        end
      end else if (bvalid && bready) begin
        bvalid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pkt_buffer.sv
module pkt_buffer #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-$clog2(DATA_W/8)-1:0] rd_idx,
  output logic [DATA_W-1:0]          rd_word
);
  localparam int unsigned WORD_LSB = $clog2(DATA_W / 8);
  localparam int unsigned DEPTH    = 2 ** (ADDR_W - WORD_LSB);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
    rd_word <= mem[rd_idx];
  end

endmodule

// File: rtl/pkt_sequencer.sv
module pkt_sequencer #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LEN_W  = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [LEN_W-1:0]           len_i,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0] rd_idx_o,
  input  logic [DATA_W-1:0]          rd_word_i,
  output logic [7:0]                 byte_o,
  output logic                       byte_valid_o,
  input  logic                       byte_ready_i,
  output logic                       busy_o
);
  import uart_pkt_pkg::*;

  localparam int unsigned WORD_LSB = $clog2(DATA_W / 8);
  localparam int unsigned LANES    = DATA_W / 8;

  seq_state_t        state;
  logic [ADDR_W-1:0] idx;
  logic [LEN_W-1:0]  len_q;
  logic              last;
  logic [7:0]        lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = rd_word_i[8*g +: 8];
  end

  assign rd_idx_o     = idx[ADDR_W-1:WORD_LSB];
  assign byte_o       = lane[idx[WORD_LSB-1:0]];
  assign byte_valid_o = (state == SQ_OFFER);
  assign busy_o       = (state != SQ_IDLE);
  assign last         = (LEN_W'(idx) == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      len_q <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (start_i && len_i != '0) begin
            len_q <= len_i;
            idx   <= '0;
            state <= SQ_FETCH;
          end
        end
        SQ_FETCH: state <= SQ_OFFER;
        SQ_OFFER: begin
          if (byte_ready_i) begin
            if (last) begin
              state <= SQ_DRAIN;
            end else begin
              idx   <= idx + ADDR_W'(1);
              state <= SQ_FETCH;
            end
          end
        end
        SQ_DRAIN: begin
          if (byte_ready_i) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/uart_serializer.sv
module uart_serializer #(
  parameter int unsigned DIV       = 868,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  output logic       tx_o
);
  localparam int unsigned FRAME  = 1 + 8 + STOP_BITS;
  localparam int unsigned LEFT_W = $clog2(FRAME + 1);
  localparam int unsigned CNT_W  = (DIV > 1) ? $clog2(DIV) : 1;

  logic [FRAME-1:0]  shreg;
  logic [LEFT_W-1:0] left;
  logic [CNT_W-1:0]  cnt;

  assign ready_o = (left == '0);
  assign tx_o    = shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      cnt   <= '0;
    end else if (left == '0) begin
      if (valid_i) begin
        shreg <= {{STOP_BITS{1'b1}}, data_i, 1'b0};
        left  <= LEFT_W'(FRAME);
        cnt   <= '0;
      end
    end else if (cnt == CNT_W'(DIV - 1)) begin
      cnt   <= '0;
      shreg <= {1'b1, shreg[FRAME-1:1]};
      left  <= left - LEFT_W'(1);
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/uart_pkt_tx.sv
module uart_pkt_tx #(
  parameter int unsigned CLK_HZ    = 100_000_000,
  parameter int unsigned BAUD      = 115_200,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned REG_AW    = 4,
  parameter int unsigned STOP_BITS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       buf_wvalid,
  output logic                       buf_wready,
  input  logic [ADDR_W-3:0]          buf_widx,
  input  logic [DATA_W-1:0]          buf_wdata,
  input  logic                       reg_awvalid,
  output logic                       reg_awready,
  input  logic [REG_AW-1:0]          reg_awaddr,
  input  logic                       reg_wvalid,
  output logic                       reg_wready,
  input  logic [DATA_W-1:0]          reg_wdata,
  output logic                       reg_bvalid,
  input  logic                       reg_bready,
  output logic                       tx,
  output logic                       busy
);
  import uart_pkt_pkg::*;

  localparam int unsigned BUF_BYTES = 2 ** ADDR_W;
  localparam int unsigned LEN_W     = $clog2(BUF_BYTES + 1);
  localparam int unsigned DIV       = bit_cycles(CLK_HZ, BAUD);
  localparam int unsigned IDX_W     = ADDR_W - $clog2(DATA_W / 8);

  logic [LEN_W-1:0]  len;
  logic              start;
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_word;
  logic [7:0]        sbyte;
  logic              svalid;
  logic              sready;

  assign buf_wready = 1'b1;

  pkt_regs #(
    .DATA_W(DATA_W), .REG_AW(REG_AW), .BUF_BYTES(BUF_BYTES), .LEN_W(LEN_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .awvalid(reg_awvalid), .awready(reg_awready), .awaddr(reg_awaddr),
    .wvalid(reg_wvalid), .wready(reg_wready), .wdata(reg_wdata),
    .bvalid(reg_bvalid), .bready(reg_bready),
    .len_o(len), .start_o(start)
  );

  pkt_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk),
    .wr_en(buf_wvalid), .wr_idx(buf_widx), .wr_data(buf_wdata),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  pkt_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start_i(start), .len_i(len),
    .rd_idx_o(rd_idx), .rd_word_i(rd_word),
    .byte_o(sbyte), .byte_valid_o(svalid), .byte_ready_i(sready),
    .busy_o(busy)
  );

  uart_serializer #(.DIV(DIV), .STOP_BITS(STOP_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n),
    .data_i(sbyte), .valid_i(svalid), .ready_o(sready),
    .tx_o(tx)
  );

endmodule

// File: rtl/uart_pkt_tx_chk.sv
module uart_pkt_tx_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REG_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx,
  input logic              busy,
  input logic              reg_awvalid,
  input logic              reg_awready,
  input logic [REG_AW-1:0] reg_awaddr,
  input logic              reg_wvalid,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_bvalid,
  input logic              reg_bready
);
  import uart_pkt_pkg::*;

  logic trig_take;
  assign trig_take = reg_awvalid && reg_awready && reg_wvalid &&
                     reg_awaddr == REG_AW'(TRIG_REG_ADDR) &&
                     reg_wdata == DATA_W'(TRIG_CODE);

  // R1
  reset_line_high_chk: assert property (@(posedge clk) !rst_n |=> tx && !busy);

  // R2
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_bvalid && !reg_bready |=> reg_bvalid);

  // R2
  no_take_while_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_awready |-> !reg_bvalid && reg_wvalid);

  // R6
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(trig_take, 2));

  // R10
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R10
  start_bit_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx) |-> busy);

endmodule

bind uart_pkt_tx uart_pkt_tx_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx(tx), .busy(busy),
  .reg_awvalid(reg_awvalid), .reg_awready(reg_awready), .reg_awaddr(reg_awaddr),
  .reg_wvalid(reg_wvalid), .reg_wdata(reg_wdata),
  .reg_bvalid(reg_bvalid), .reg_bready(reg_bready)
);

// File: tb/uart_pkt_tx_test.sv
`timescale 1ns/1ps
module uart_pkt_tx_test;
  localparam int CLK_HZ = 8;
  localparam int BAUD   = 1;
  localparam int DIV    = 8;
  localparam int ADDR_W = 6;
  localparam int NBYTES = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_wvalid = 1'b0;
  logic        buf_wready;
  logic [3:0]  buf_widx = '0;
  logic [31:0] buf_wdata = '0;
  logic        reg_awvalid = 1'b0;
  logic        reg_awready;
  logic [3:0]  reg_awaddr = '0;
  logic        reg_wvalid = 1'b0;
  logic        reg_wready;
  logic [31:0] reg_wdata = '0;
  logic        reg_bvalid;
  logic        reg_bready = 1'b1;
  logic        tx;
  logic        busy;

  int n_tests = 0;
  int n_fail  = 0;
  int frames  = 0;
  bit done    = 1'b0;
  logic [7:0] model [NBYTES];
  logic [7:0] sb_q [$];

  always #4 clk = ~clk;

  uart_pkt_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .buf_wvalid(buf_wvalid), .buf_wready(buf_wready), .buf_widx(buf_widx), .buf_wdata(buf_wdata),
    .reg_awvalid(reg_awvalid), .reg_awready(reg_awready), .reg_awaddr(reg_awaddr),
    .reg_wvalid(reg_wvalid), .reg_wready(reg_wready), .reg_wdata(reg_wdata),
    .reg_bvalid(reg_bvalid), .reg_bready(reg_bready),
    .tx(tx), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic buf_write(input int widx, input logic [31:0] w);
    buf_wvalid = 1'b1;
    buf_widx   = 4'(widx);
    buf_wdata  = w;
    for (int k = 0; k < 4; k++) model[4*widx+k] = w[8*k +: 8];
    tick(1);
    buf_wvalid = 1'b0;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    reg_awvalid = 1'b1;
    reg_wvalid  = 1'b1;
    reg_awaddr  = a;
    reg_wdata   = d;
    while (!reg_awready) tick(1);
    tick(1);
    reg_awvalid = 1'b0;
    reg_wvalid  = 1'b0;
  endtask

  // driver: push the expected bytes, then start
  task automatic send_packet(input int len);
    int n;
    n = (len > NBYTES) ? NBYTES : len;
    for (int i = 0; i < n; i++) sb_q.push_back(model[i]);
    reg_write(4'h0, 32'(len));
    reg_write(4'h4, 32'h0000_00BA);
  endtask

  task automatic wait_idle(input string req);
    int guard;
    guard = 0;
    tick(3);
    while (busy && guard < 20000) begin
      tick(1);
      guard++;
    end
    tick(2);
    chk(tx == 1'b1, "R10", "tx high after packet", int'(tx), 1);
    chk(sb_q.size() == 0, req, "frames still missing", sb_q.size(), 0);
  endtask

  // monitor: decode frames and compare with the scoreboard
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    bit lastb;
    forever begin
      @(negedge tx);
      if (rst_n) begin
        tick(DIV / 2);
        chk(tx == 1'b0, "R9", "start bit", int'(tx), 0);
        for (int i = 0; i < 8; i++) begin
          tick(DIV);
          b[i] = tx;
        end
        lastb = (sb_q.size() == 1);
        for (int s = 0; s < 2; s++) begin
          tick(DIV);
          chk(tx == 1'b1, "R9", "stop bit", int'(tx), 1);
          if (lastb && s == 1) chk(busy == 1'b1, "R10", "busy in last stop bit", int'(busy), 1);
        end
        frames++;
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7", "unexpected frame", int'(b), 0);
        end else begin
          e = sb_q.pop_front();
          chk(b == e, "R8", "byte value", int'(b), int'(e));
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R10", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    tick(4);
    // R1 reset values
    chk(tx == 1'b1, "R1", "tx in reset", int'(tx), 1);
    chk(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
    chk(reg_bvalid == 1'b0, "R1", "bvalid in reset", int'(reg_bvalid), 0);
    rst_n = 1'b1;
    tick(2);
    chk(buf_wready == 1'b1, "R11", "buf_wready", int'(buf_wready), 1);

    // R5 length still zero after reset: start sends nothing
    reg_write(4'h4, 32'h0000_00BA);
    tick(20);
    chk(busy == 1'b0, "R5", "busy with zero length", int'(busy), 0);
    chk(frames == 0, "R5", "frames with zero length", frames, 0);

    // R2 handshake and back-pressure
    reg_bready  = 1'b0;
    reg_awvalid = 1'b1;
    reg_awaddr  = 4'h0;
    reg_wdata   = 32'd3;
    #1;
    chk(reg_awready == 1'b0 && reg_wready == 1'b0, "R2", "ready without wvalid", int'(reg_awready), 0);
    reg_wvalid = 1'b1;
    #1;
    chk(reg_awready == 1'b1 && reg_wready == 1'b1, "R2", "ready with both valid", int'(reg_awready), 1);
    tick(1);
    chk(reg_bvalid == 1'b1, "R2", "bvalid after accept", int'(reg_bvalid), 1);
    chk(reg_awready == 1'b0, "R2", "no accept while response pending", int'(reg_awready), 0);
    reg_awvalid = 1'b0;
    reg_wvalid  = 1'b0;
    tick(3);
    chk(reg_bvalid == 1'b1, "R2", "bvalid held", int'(reg_bvalid), 1);
    reg_bready = 1'b1;
    tick(1);
    chk(reg_bvalid == 1'b0, "R2", "bvalid cleared", int'(reg_bvalid), 0);

    // R8 R11 byte order within and across words
    buf_write(0, 32'hBA03_21F1);
    buf_write(1, 32'h3129_A5BD);
    send_packet(8);
    wait_idle("R8");

    // R3 length not a multiple of four
    buf_write(0, 32'h0302_0100);
    buf_write(1, 32'h0706_0504);
    send_packet(5);
    wait_idle("R3");
    chk(frames == 13, "R3", "total frames", frames, 13);

    // R6 wrong codes and wrong addresses are ignored
    f0 = frames;
    reg_write(4'h4, 32'h0000_00BB);
    reg_write(4'h4, 32'h0000_01BA);
    reg_write(4'h8, 32'h0000_00BA);
    reg_write(4'h5, 32'h0000_00BA);
    tick(30);
    chk(busy == 1'b0, "R6", "busy after bad starts", int'(busy), 0);
    chk(frames == f0, "R6", "frames after bad starts", frames, f0);

    // R7 start during a packet is ignored
    buf_write(0, 32'hC3C2_C1C0);
    send_packet(3);
    tick(40);
    chk(busy == 1'b1, "R10", "busy mid packet", int'(busy), 1);
    reg_write(4'h4, 32'h0000_00BA);
    wait_idle("R7");
    tick(300);
    chk(frames == f0 + 3, "R7", "frames after start while busy", frames, f0 + 3);

    // R4 clamp to the buffer size
    for (int w = 0; w < NBYTES / 4; w++) begin
      buf_write(w, {8'(4*w+3) ^ 8'h5A, 8'(4*w+2), 8'(4*w+1) ^ 8'hA5, 8'(4*w)});
    end
    f0 = frames;
    send_packet(256);
    wait_idle("R4");
    tick(300);
    chk(frames == f0 + NBYTES, "R4", "frames with clamped length", frames, f0 + NBYTES);

    finish_run();
  end

endmodule